// File: doc/BRIEF.md
# Flash In-Application Programming Controller

This block lets software running on the CPU modify its own on-chip flash through a small byte-wide register bus. Software loads a target address and a data byte, then issues one of four commands through a control register: program a single byte, erase a 512-byte page, erase the whole device, or turn on read-out protection. A start command is honoured only when it directly follows a three-byte unlock key written into the data register, and only when the function is enabled in a system-enable register. Each accepted key is spent by the next start, so every operation needs its own key.

The flash store has two zones, program and data, each of `2**ADDR_W` bytes. The lowest `BOOT_PAGES` pages of the program zone hold a resident boot image that no command can change. Each operation holds a busy flag for a parameterised number of cycles. While busy, the erase engine walks the affected bytes one per cycle, and all bus writes are ignored. Reads of flash through the bus return 00h whenever protection is on. Illegal requests set an error flag and change nothing.

Top module: `flash_iap_ctrl`

## Requirements
- R1: The unlock key is the data-register (address 0) writes 55h, AAh, 55h in that order. Any other value breaks the sequence, and a 55h restarts it. A start command that arrives without a complete key does nothing: busy stays low and flash is unchanged. A data-register write after a complete key keeps the key armed.
- R2: Every control-register write with bit 7 set spends the key, whether or not an operation runs. A second start without a new key does nothing.
- R3: A start runs only when system-enable (address 4) bit 2 is set. A start that selects the data zone (control bit 5) while system-enable bit 3 is clear sets the error flag and performs no operation.
- R4: The control register (address 3) uses bit 7 as start, bit 5 as zone (1 = data zone), and bits 2:0 as the command: 001 program, 010 page erase, 100 chip erase, 110 protect. Any other command code sets the error flag and performs no operation.
- R5: Byte program writes the data-register value to byte `{addr_hi,addr_lo}` (low ADDR_W bits) of the selected zone.
- R6: Page erase sets to FFh the 512 bytes whose base is address-high with bit 0 cleared (odd and even address-high values pick the same page). A non-zero address-low (address 2) sets the error flag and erases nothing.
- R7: The boot region is the program-zone pages below BOOT_PAGES, preloaded with byte value equal to the low 8 bits of its index. It is never altered. A program or page erase aimed at it sets the error flag and does nothing.
- R8: Chip erase sets every non-boot byte of both zones to FFh and clears protection.
- R9: After a protect command completes, every flash read returns 00h and status bit 2 and `prot_o` are 1, until a chip erase completes.
- R10: An accepted operation holds busy (`busy_o`, status bit 0) high for exactly its cycle count: CYC_PROG, max(CYC_PAGE, 512), max(CYC_CHIP, 2·2^ADDR_W) or CYC_PROT.
- R11: Every bus write is ignored while busy is high.
- R12: Each enabled, keyed start updates the error flag (`err_o`, status bit 1): it is set for a rejected request and cleared for an accepted one.
- R13: Reads are registered with one cycle of latency. Address 5 returns status and address 6 returns the flash byte at `{addr_hi,addr_lo}` in the zone given by system-enable bit 3. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| busy_o | output | 1 | Operation in progress |
| err_o | output | 1 | Last keyed start was rejected |
| prot_o | output | 1 | Read-out protection active |

## Verification
The hardest state to reach from the ports is a fully unlocked controller whose start is then refused for a subtle reason: boot target, non-zero low address, disabled zone or an unknown command code. Each refusal must leave flash byte-for-byte intact. The stimulus reaches it by running a table of complete unlock-and-start sequences, so that legal and refused requests are interleaved. After each step it reads back both zones byte by byte and compares them with a reference image. Directed cases then break the key order, reuse a spent key, and hit the bus with writes during a running erase.

// File: rtl/fiap_pkg.sv
package fiap_pkg;
  localparam logic [2:0] RA_DATA   = 3'd0;
  localparam logic [2:0] RA_AHI    = 3'd1;
  localparam logic [2:0] RA_ALO    = 3'd2;
  localparam logic [2:0] RA_CTRL   = 3'd3;
  localparam logic [2:0] RA_SYSEN  = 3'd4;
  localparam logic [2:0] RA_STATUS = 3'd5;
  localparam logic [2:0] RA_FLASH  = 3'd6;

  localparam int CT_START = 7;
  localparam int CT_ZONE  = 5;
  localparam int SE_EN    = 2;
  localparam int SE_DZONE = 3;

  localparam logic [2:0] OP_PROG  = 3'b001;
  localparam logic [2:0] OP_PAGE  = 3'b010;
  localparam logic [2:0] OP_CHIP  = 3'b100;
  localparam logic [2:0] OP_PROT  = 3'b110;

  localparam logic [7:0] KEY_A = 8'h55;
  localparam logic [7:0] KEY_B = 8'hAA;
  localparam logic [7:0] ERASED = 8'hFF;
endpackage

// File: rtl/fiap_key_detect.sv
module fiap_key_detect
  import fiap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       data_we,
  input  logic [7:0] data_val,
  input  logic       consume,
  output logic       armed
);
  typedef enum logic [1:0] {K_IDLE, K_GOT1, K_GOT2, K_ARMED} kstate_e;
  kstate_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= K_IDLE;
    end else if (consume) begin
      st_q <= K_IDLE;
    end else if (data_we) begin
      case (st_q)
        K_IDLE:  st_q <= (data_val == KEY_A) ? K_GOT1 : K_IDLE;
        K_GOT1:  st_q <= (data_val == KEY_B) ? K_GOT2 :
                         (data_val == KEY_A) ? K_GOT1 : K_IDLE;
        K_GOT2:  st_q <= (data_val == KEY_A) ? K_ARMED : K_IDLE;
        default: st_q <= K_ARMED;
      endcase
    end
  end

  assign armed = (st_q == K_ARMED);

  AST_ARM_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ($past(data_we) && $past(data_val) == KEY_A)); // R1
endmodule

// File: rtl/fiap_flash_mem.sv
module fiap_flash_mem #(
  parameter int MAW        = 11,
  parameter int BOOT_BYTES = 512
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [MAW-1:0] raddr,
  output logic [7:0]     rdata
);
  localparam int DEPTH = 1 << MAW;
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = (i < BOOT_BYTES) ? 8'(i) : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fiap_seq.sv
module fiap_seq
  import fiap_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 9,
  parameter int BOOT_PAGES = 1,
  parameter int CYC_PROG   = 40,
  parameter int CYC_PAGE   = 1200,
  parameter int CYC_CHIP   = 4000,
  parameter int CYC_PROT   = 30,
  localparam int MAW       = ADDR_W + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     op_in,
  input  logic [MAW-1:0] idx_in,
  input  logic [7:0]     data_in,
  output logic           busy,
  output logic           mem_we,
  output logic [MAW-1:0] mem_waddr,
  output logic [7:0]     mem_wdata,
  output logic           prot_set,
  output logic           prot_clr
);
  localparam int PB     = 1 << PAGE_W;
  localparam int MB     = 1 << MAW;
  localparam int PGW    = ADDR_W - PAGE_W;
  localparam int L_PROG = (CYC_PROG < 1) ? 1 : CYC_PROG;
  localparam int L_PAGE = (CYC_PAGE < PB) ? PB : CYC_PAGE;
  localparam int L_CHIP = (CYC_CHIP < MB) ? MB : CYC_CHIP;
  localparam int L_PROT = (CYC_PROT < 1) ? 1 : CYC_PROT;
  localparam int LM1    = (L_PROG > L_PAGE) ? L_PROG : L_PAGE;
  localparam int LM2    = (L_CHIP > L_PROT) ? L_CHIP : L_PROT;
  localparam int LMAX   = (LM1 > LM2) ? LM1 : LM2;
  localparam int CW     = $clog2(LMAX + 1);
  localparam logic [PGW:0] BOOT_LIM = (PGW+1)'(BOOT_PAGES);

  logic           busy_q;
  logic [CW-1:0]  cnt_q;
  logic [2:0]     op_q;
  logic [MAW-1:0] base_q;
  logic [7:0]     data_q;
  logic [CW-1:0]  lim;
  logic           done;
  logic           boot_w;

  always_comb begin
    case (op_q)
      OP_PROG: lim = CW'(L_PROG);
      OP_PAGE: lim = CW'(L_PAGE);
      OP_CHIP: lim = CW'(L_CHIP);
      OP_PROT: lim = CW'(L_PROT);
      default: lim = CW'(1);
    endcase
  end

  assign done = busy_q && (cnt_q == lim - CW'(1));

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = base_q;
    mem_wdata = ERASED;
    case (op_q)
      OP_PROG: begin
        mem_we    = busy_q && (cnt_q == '0);
        mem_wdata = data_q;
      end
      OP_PAGE: begin
        mem_waddr = {base_q[MAW-1:PAGE_W], cnt_q[PAGE_W-1:0]};
        mem_we    = busy_q && (cnt_q < CW'(PB));
      end
      OP_CHIP: begin
        mem_waddr = cnt_q[MAW-1:0];
        mem_we    = busy_q && (cnt_q < CW'(MB)) && !boot_w;
      end
      default: ;
    endcase
  end

  assign boot_w = !mem_waddr[MAW-1] &&
                  ({1'b0, mem_waddr[ADDR_W-1:PAGE_W]} < BOOT_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= '0;
      base_q <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      op_q   <= op_in;
      base_q <= idx_in;
      data_q <= data_in;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign busy     = busy_q;
  assign prot_set = done && (op_q == OP_PROT);
  assign prot_clr = done && (op_q == OP_CHIP);

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q); // R11
  AST_BOOT_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !boot_w); // R7
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> busy_q); // R10
endmodule

// File: rtl/flash_iap_ctrl.sv
module flash_iap_ctrl
  import fiap_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 9,
  parameter int BOOT_PAGES = 1,
  parameter int CYC_PROG   = 40,
  parameter int CYC_PAGE   = 1200,
  parameter int CYC_CHIP   = 4000,
  parameter int CYC_PROT   = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy_o,
  output logic       err_o,
  output logic       prot_o
);
  localparam int MAW = ADDR_W + 1;
  localparam int PGW = ADDR_W - PAGE_W;
  localparam logic [PGW:0] BOOT_LIM = (PGW+1)'(BOOT_PAGES);

  logic [7:0] data_q, ahi_q, alo_q, ctrl_q, sysen_q;
  logic       err_q, prot_q;
  logic       busy, armed, wr_ok, start_req, go, reject, launch;
  logic       prot_set, prot_clr;
  logic [15:0] full_a;
  logic [2:0]  op_code;
  logic        zone_sel, boot_hit, op_legal;
  logic [MAW-1:0] tgt_idx, rd_idx, mem_waddr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata, rd_mux;

  assign wr_ok     = bus_we && !busy;
  assign start_req = wr_ok && (bus_addr == RA_CTRL) && bus_wdata[CT_START];
  assign go        = start_req && armed && sysen_q[SE_EN];
  assign full_a    = {ahi_q, alo_q};
  assign op_code   = bus_wdata[2:0];
  assign zone_sel  = bus_wdata[CT_ZONE];
  assign tgt_idx   = {zone_sel, full_a[ADDR_W-1:0]};
  assign rd_idx    = {sysen_q[SE_DZONE], full_a[ADDR_W-1:0]};
  assign boot_hit  = !zone_sel && ({1'b0, full_a[ADDR_W-1:PAGE_W]} < BOOT_LIM);
  assign op_legal  = (op_code == OP_PROG) || (op_code == OP_PAGE) ||
                     (op_code == OP_CHIP) || (op_code == OP_PROT);

  always_comb begin
    reject = !op_legal || (zone_sel && !sysen_q[SE_DZONE]);
    if (op_code == OP_PAGE) reject = reject || (alo_q != 8'h00) || boot_hit;
    if (op_code == OP_PROG) reject = reject || boot_hit;
  end

  assign launch = go && !reject;

  fiap_key_detect u_key (
    .clk      (clk),
    .rst      (rst),
    .data_we  (wr_ok && (bus_addr == RA_DATA)),
    .data_val (bus_wdata),
    .consume  (start_req),
    .armed    (armed)
  );

  fiap_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BOOT_PAGES(BOOT_PAGES),
    .CYC_PROG(CYC_PROG), .CYC_PAGE(CYC_PAGE),
    .CYC_CHIP(CYC_CHIP), .CYC_PROT(CYC_PROT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (launch),
    .op_in     (op_code),
    .idx_in    (tgt_idx),
    .data_in   (data_q),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .prot_set  (prot_set),
    .prot_clr  (prot_clr)
  );

  fiap_flash_mem #(
    .MAW(MAW), .BOOT_BYTES(BOOT_PAGES << PAGE_W)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_idx),
    .rdata (mem_rdata)
  );

  always_comb begin
    case (bus_addr)
      RA_DATA:   rd_mux = data_q;
      RA_AHI:    rd_mux = ahi_q;
      RA_ALO:    rd_mux = alo_q;
      RA_CTRL:   rd_mux = ctrl_q;
      RA_SYSEN:  rd_mux = sysen_q;
      RA_STATUS: rd_mux = {5'b0, prot_q, err_q, busy};
      RA_FLASH:  rd_mux = prot_q ? 8'h00 : mem_rdata;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      ahi_q     <= '0;
      alo_q     <= '0;
      ctrl_q    <= '0;
      sysen_q   <= '0;
      err_q     <= 1'b0;
      prot_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ok) begin
        case (bus_addr)
          RA_DATA:  data_q  <= bus_wdata;
          RA_AHI:   ahi_q   <= bus_wdata;
          RA_ALO:   alo_q   <= bus_wdata;
          RA_CTRL:  ctrl_q  <= {1'b0, bus_wdata[6:0]};
          RA_SYSEN: sysen_q <= bus_wdata;
          default: ;
        endcase
      end
      if (go) err_q <= reject;
      if (prot_set)      prot_q <= 1'b1;
      else if (prot_clr) prot_q <= 1'b0;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  assign busy_o = busy;
  assign err_o  = err_q;
  assign prot_o = prot_q;

  AST_PROT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == RA_FLASH && prot_q) |=> (bus_rdata == 8'h00)); // R9
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == RA_AHI) |=> (ahi_q == $past(ahi_q))); // R11
  AST_REJECT_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (go && reject) |=> (!busy_o && err_o)); // R12
  AST_UNKEYED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start_req && !armed && !busy) |=> !busy_o); // R1
endmodule

// File: tb/flash_iap_ctrl_tb_top.sv
module flash_iap_ctrl_tb_top;
  localparam int AW = 10, PW = 9, BP = 1;
  localparam int CP = 6, CG = 520, CC = 2060, CT = 15;
  localparam int ZB = 1 << AW, MB = 2 * ZB, PB = 1 << PW;
  localparam int L_PROG = CP;
  localparam int L_PAGE = (CG > PB) ? CG : PB;
  localparam int L_CHIP = (CC > MB) ? CC : MB;
  localparam int L_PROT = CT;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic busy_o, err_o, prot_o;

  flash_iap_ctrl #(
    .ADDR_W(AW), .PAGE_W(PW), .BOOT_PAGES(BP),
    .CYC_PROG(CP), .CYC_PAGE(CG), .CYC_CHIP(CC), .CYC_PROT(CT)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_o(busy_o), .err_o(err_o), .prot_o(prot_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] refm [MB];
  bit prot_m = 1'b0;

  // {op[2:0], zone, addr_hi, addr_lo, data, expect_error}
  localparam logic [28:0] TBL [14] = '{
    {3'd1, 1'b1, 8'h01, 8'h23, 8'h5A, 1'b0},
    {3'd1, 1'b0, 8'h02, 8'hF0, 8'hC3, 1'b0},
    {3'd1, 1'b0, 8'h00, 8'h10, 8'h99, 1'b1},
    {3'd2, 1'b0, 8'h03, 8'h00, 8'h00, 1'b0},
    {3'd1, 1'b1, 8'h03, 8'hFF, 8'h77, 1'b0},
    {3'd2, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0},
    {3'd2, 1'b0, 8'h01, 8'h00, 8'h00, 1'b1},
    {3'd2, 1'b1, 8'h02, 8'h05, 8'h00, 1'b1},
    {3'd3, 1'b0, 8'h02, 8'h00, 8'h00, 1'b1},
    {3'd1, 1'b0, 8'h02, 8'h50, 8'h11, 1'b0},
    {3'd6, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    {3'd1, 1'b1, 8'h02, 8'h00, 8'h44, 1'b0},
    {3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    {3'd1, 1'b0, 8'h03, 8'hA0, 8'hE1, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      2, 6:    return "R7";
      7:       return "R6";
      8:       return "R4";
      3, 5:    return "R6";
      10, 11:  return "R9";
      12:      return "R8";
      default: return "R5";
    endcase
  endfunction

  function automatic int idx_of(bit z, logic [7:0] ah, logic [7:0] al);
    return (z ? ZB : 0) + ({ah, al} % ZB);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic send_key();
    wr(3'd0, 8'h55); wr(3'd0, 8'hAA); wr(3'd0, 8'h55);
  endtask

  task automatic do_op(logic [2:0] op, bit z, logic [7:0] ah, logic [7:0] al, logic [7:0] d);
    send_key();
    wr(3'd0, d); wr(3'd1, ah); wr(3'd2, al);
    wr(3'd3, 8'h80 | (8'(z) << 5) | 8'(op));
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      @(posedge clk); #1;
    end
  endtask

  task automatic apply_ref(logic [2:0] op, bit z, logic [7:0] ah, logic [7:0] al, logic [7:0] d);
    int base;
    case (op)
      3'd1: refm[idx_of(z, ah, al)] = d;
      3'd2: begin
        base = idx_of(z, ah & 8'hFE, 8'h00);
        for (int i = 0; i < PB; i++) refm[base + i] = 8'hFF;
      end
      3'd4: begin
        for (int i = BP * PB; i < MB; i++) refm[i] = 8'hFF;
        prot_m = 1'b0;
      end
      3'd6: prot_m = 1'b1;
      default: ;
    endcase
  endtask

  task automatic compare_all(string req);
    int mism = 0, fa = 0, fe = 0;
    logic [7:0] v, e;
    for (int z = 0; z < 2; z++) begin
      wr(3'd4, (z != 0) ? 8'h0C : 8'h04);
      for (int a = 0; a < ZB; a++) begin
        if (a % 256 == 0) wr(3'd1, 8'(a >> 8));
        wr(3'd2, 8'(a));
        idle();
        rd(3'd6, v);
        e = prot_m ? 8'h00 : refm[z * ZB + a];
        if (v !== e) begin
          if (mism == 0) begin fa = int'(v); fe = int'(e); end
          mism++;
        end
      end
    end
    wr(3'd4, 8'h0C);
    chk(mism == 0, req, fa, fe);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, ix;
    for (int i = 0; i < MB; i++) refm[i] = (i < BP * PB) ? 8'(i) : 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle();

    // R13 reset state
    rd(3'd5, v); chk(v == 8'h00, "R13 status", v, 0);
    rd(3'd1, v); chk(v == 8'h00, "R13 addr_hi", v, 0);
    chk(busy_o == 1'b0, "R10 idle after reset", busy_o, 0);

    wr(3'd4, 8'h0C);
    compare_all("R7 boot image");

    for (int i = 0; i < 14; i++) begin
      logic [2:0] op; bit z, e; logic [7:0] ah, al, d; int lexp;
      op = TBL[i][28:26]; z = TBL[i][25]; ah = TBL[i][24:17];
      al = TBL[i][16:9];  d = TBL[i][8:1]; e = TBL[i][0];
      do_op(op, z, ah, al, d);
      wait_idle(n);
      case (op)
        3'd1: lexp = L_PROG;
        3'd2: lexp = L_PAGE;
        3'd4: lexp = L_CHIP;
        3'd6: lexp = L_PROT;
        default: lexp = 0;
      endcase
      if (e) lexp = 0;
      chk(n == lexp, "R10 busy length", n, lexp);
      chk(err_o == e, "R12 error flag", err_o, e);
      if (!e) apply_ref(op, z, ah, al, d);
      if (op == 3'd6) chk(prot_o == 1'b1, "R9 protect flag", prot_o, 1);
      if (op == 3'd4) chk(prot_o == 1'b0, "R8 protect cleared", prot_o, 0);
      compare_all(tag_of(i));
    end

    // R1 broken key order: start must not run
    wr(3'd0, 8'h55); wr(3'd0, 8'hAA); wr(3'd0, 8'hAA); wr(3'd0, 8'h55);
    wr(3'd1, 8'h03); wr(3'd2, 8'h00); wr(3'd3, 8'h81);
    chk(busy_o == 1'b0, "R1 broken key", busy_o, 0);
    wr(3'd4, 8'h04); wr(3'd1, 8'h03); wr(3'd2, 8'h00); idle();
    rd(3'd6, v); chk(v == refm[idx_of(0, 8'h03, 8'h00)], "R1 flash unchanged", v, refm[idx_of(0, 8'h03, 8'h00)]);
    wr(3'd4, 8'h0C);

    // R2 key spent by a start
    do_op(3'd1, 1'b0, 8'h03, 8'h01, 8'h12); wait_idle(n);
    apply_ref(3'd1, 1'b0, 8'h03, 8'h01, 8'h12);
    wr(3'd0, 8'h34); wr(3'd3, 8'h81);
    chk(busy_o == 1'b0, "R2 spent key", busy_o, 0);
    wr(3'd4, 8'h04); wr(3'd1, 8'h03); wr(3'd2, 8'h01); idle();
    rd(3'd6, v); chk(v == 8'h12, "R2 byte kept", v, 8'h12);

    // R3 enable bit clear
    wr(3'd4, 8'h00);
    do_op(3'd1, 1'b0, 8'h03, 8'h02, 8'h21);
    chk(busy_o == 1'b0, "R3 disabled", busy_o, 0);
    // R3 data zone without zone enable
    wr(3'd4, 8'h04);
    do_op(3'd1, 1'b1, 8'h03, 8'h02, 8'h21);
    chk(busy_o == 1'b0 && err_o == 1'b1, "R3 zone not enabled", {busy_o, err_o}, 1);
    wr(3'd4, 8'h0C);

    // R11 writes ignored while busy; R10 busy in status
    do_op(3'd2, 1'b0, 8'h03, 8'h00, 8'h00);
    chk(err_o == 1'b0, "R12 error cleared", err_o, 0);
    wr(3'd1, 8'hEE);
    rd(3'd5, v); chk(v[0] == 1'b1, "R10 status busy", v, 1);
    wait_idle(n);
    apply_ref(3'd2, 1'b0, 8'h03, 8'h00, 8'h00);
    rd(3'd1, v); chk(v == 8'h03, "R11 addr_hi kept", v, 8'h03);

    compare_all("R11 final image");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule